// File: doc/BRIEF.md
# USB Device Interrupt Pending Register

This block gathers the events of a USB device core into one byte of sticky flags and one interrupt line for the microcontroller. Power-management and endpoint events arrive as one-cycle strobes. Control-endpoint (endpoint 0) activity arrives as five level status flags. The block samples these flags once per clock and turns selected edges into one endpoint-0 event.

The MCU reads the byte on a read port. The read strobe returns the value that is held now, and the register clears at the same clock edge. An event that arrives in the cycle of that read is not lost. The interrupt line stays high while any flag is set. A suspend tracker inside the block accepts a resume event only while the device is suspended, and each accepted resume ends the suspended state.

Top module: `usb_irq_pend`

## Requirements
- R1: The flag byte is laid out as follows: bit 0 endpoint 0, bit 1 endpoint 1, bit 2 suspend, bit 3 resume, bit 4 endpoint 2, bit 5 bus reset. Bits 7 and 6 always read as zero.
- R2: A cycle with `rd_en` high returns the current byte on `rd_data`, and all flags are zero after that clock edge unless a new event arrived in that cycle.
- R3: `irq` is high exactly when at least one flag is set.
- R4: A resume strobe sets bit 3 only if a suspend strobe came earlier and no accepted resume has ended that suspend. In any other case the resume strobe has no effect.
- R5: Bit 0 is set when `ep0_out_rdy`, `ep0_stall_sent` or `ep0_setup_end` goes from 0 to 1. The opposite edge of these flags, and a flag that stays high, do not set it.
- R6: Bit 0 is set when `ep0_in_rdy` or `ep0_data_end` goes from 1 to 0. A rising edge of these flags does not set it.
- R7: The strobes `ev_bus_reset`, `ev_suspend`, `ev_ep1` and `ev_ep2` each set their own bit one clock after they are high.
- R8: An event in the same cycle as a read stays set after that read.
- R9: After a resume is accepted, a further resume strobe does nothing until a new suspend strobe arrives.
- R10: A set flag stays set until the MCU reads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | MCU read strobe; clears the register at the clock edge |
| rd_data | output | 8 | Current flag byte |
| irq | output | 1 | Interrupt request, high while any flag is set |
| ev_bus_reset | input | 1 | Strobe: bus reset detected |
| ev_suspend | input | 1 | Strobe: suspend detected |
| ev_resume | input | 1 | Strobe: resume detected |
| ev_ep1 | input | 1 | Strobe: endpoint 1 needs service |
| ev_ep2 | input | 1 | Strobe: endpoint 2 needs service |
| ep0_out_rdy | input | 1 | Endpoint-0 received-packet-ready flag |
| ep0_in_rdy | input | 1 | Endpoint-0 transmit-packet-ready flag |
| ep0_stall_sent | input | 1 | Endpoint-0 stall-sent flag |
| ep0_data_end | input | 1 | Endpoint-0 data-end flag |
| ep0_setup_end | input | 1 | Endpoint-0 setup-end flag |

## Verification
Each endpoint-0 flag is driven through a full rise-hold-fall cycle, with a read between the steps. This shows the active edge apart from the opposite edge and from a flag that stays high. The resume strobe is applied three ways: with no suspend before it, after a suspend, and a second time after an accepted resume. This shows the suspend gate and the end of the suspended state. Each strobe is also applied alone to check its bit position, and all strobes together to check the full mask. A read that meets an event in the same cycle shows whether the event or the clear wins.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int PND_W     = 8;
    localparam int BIT_EP0   = 0;
    localparam int BIT_EP1   = 1;
    localparam int BIT_SUSP  = 2;
    localparam int BIT_RES   = 3;
    localparam int BIT_EP2   = 4;
    localparam int BIT_RST   = 5;
    localparam int USED_W    = BIT_RST + 1;
    localparam int EP0_FLAGS = 5;
    // flag order: out_rdy, in_rdy, stall_sent, data_end, setup_end
    // 1 = rising edge counts, 0 = falling edge counts
    localparam logic [EP0_FLAGS-1:0] EP0_RISE = 5'b10101;

    typedef struct packed {
        logic [PND_W-1:0] pend;
    } pend_state_t;
endpackage

// File: rtl/ep0_edge_det.sv
module ep0_edge_det #(
    parameter int N = 5,
    parameter logic [N-1:0] RISE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    output logic         evt_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_q, st_d;
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_edge
            if (RISE_MASK[i]) begin : g_rise
                assign hit[i] = flags_i[i] & ~st_q.prev[i];
            end else begin : g_fall
                assign hit[i] = ~flags_i[i] & st_q.prev[i];
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = flags_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = |hit;

    // R5: a rising edge of the received-packet flag must raise the event
    assert_out_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (RISE_MASK[0] && $rose(flags_i[0])) |-> evt_o);
endmodule

// File: rtl/susp_track.sv
module susp_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_suspend,
    input  logic ev_resume,
    output logic resume_ok_o,
    output logic active_o
);
    typedef struct packed {
        logic susp;
    } susp_state_t;

    susp_state_t st_q, st_d;

    assign resume_ok_o = ev_resume & st_q.susp;
    assign active_o    = st_q.susp;

    always_comb begin
        st_d = st_q;
        if (ev_suspend)       st_d.susp = 1'b1;
        else if (resume_ok_o) st_d.susp = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_leave_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_ok_o && !ev_suspend) |=> !active_o);
endmodule

// File: rtl/usb_irq_pend.sv
module usb_irq_pend
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    output logic [PND_W-1:0] rd_data,
    output logic             irq,
    input  logic             ev_bus_reset,
    input  logic             ev_suspend,
    input  logic             ev_resume,
    input  logic             ev_ep1,
    input  logic             ev_ep2,
    input  logic             ep0_out_rdy,
    input  logic             ep0_in_rdy,
    input  logic             ep0_stall_sent,
    input  logic             ep0_data_end,
    input  logic             ep0_setup_end
);
    pend_state_t      st_q, st_d;
    logic             ep0_evt;
    logic             res_ok;
    logic             susp_active;
    logic [PND_W-1:0] set_vec;
    logic [PND_W-1:0] used_mask;

    ep0_edge_det #(.N(EP0_FLAGS), .RISE_MASK(EP0_RISE)) u_ep0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i ({ep0_setup_end, ep0_data_end, ep0_stall_sent,
                   ep0_in_rdy, ep0_out_rdy}),
        .evt_o   (ep0_evt)
    );

    susp_track u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_suspend  (ev_suspend),
        .ev_resume   (ev_resume),
        .resume_ok_o (res_ok),
        .active_o    (susp_active)
    );

    always_comb begin
        used_mask = '0;
        used_mask[USED_W-1:0] = '1;
        set_vec = '0;
        set_vec[BIT_EP0]  = ep0_evt;
        set_vec[BIT_EP1]  = ev_ep1;
        set_vec[BIT_SUSP] = ev_suspend;
        set_vec[BIT_RES]  = res_ok;
        set_vec[BIT_EP2]  = ev_ep2;
        set_vec[BIT_RST]  = ev_bus_reset;
    end

    always_comb begin
        st_d = st_q;
        st_d.pend = ((rd_en ? '0 : st_q.pend) | set_vec) & used_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.pend;
    assign irq     = |st_q.pend;

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[PND_W-1:USED_W] == '0);

    assert_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ev_bus_reset && !ev_ep2 && !ev_suspend && !ev_ep1 &&
         !res_ok && !ep0_evt) |=> (rd_data == '0));

    assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ep1 |=> irq);

    assert_resume_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !susp_active) |=> !rd_data[BIT_RES]);

    assert_ep0_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_evt |=> rd_data[BIT_EP0]);

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ev_ep2) |=> rd_data[BIT_EP2]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && rd_data[BIT_EP1]) |=> rd_data[BIT_EP1]);
endmodule

// File: tb/tb_usb_irq_pend.sv
module tb_usb_irq_pend;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    // strobe vector: {bus_reset, ep2, resume, suspend, ep1}
    logic [4:0] stb = '0;
    // ep0 flags: {setup_end, data_end, stall_sent, in_rdy, out_rdy}
    logic [4:0] f0 = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usb_irq_pend dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
        .ev_bus_reset(stb[4]), .ev_suspend(stb[1]), .ev_resume(stb[2]),
        .ev_ep1(stb[0]), .ev_ep2(stb[3]),
        .ep0_out_rdy(f0[0]), .ep0_in_rdy(f0[1]), .ep0_stall_sent(f0[2]),
        .ep0_data_end(f0[3]), .ep0_setup_end(f0[4])
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] s);
        @(negedge clk); stb = s;
        @(negedge clk); stb = '0;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_f0(input int idx, input logic val);
        @(negedge clk); f0[idx] = val;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R2 reset rd_data", rd_data, 8'h00);
        check("R3 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_strobes();
        logic [7:0] v;
        pulse(5'b00001);
        check("R7 ep1 bit", rd_data, 8'h02);
        check("R3 irq high", {7'd0, irq}, 8'h01);
        repeat (4) @(negedge clk);
        check("R10 held", rd_data, 8'h02);
        do_read(v);
        check("R2 read value", v, 8'h02);
        check("R2 cleared", rd_data, 8'h00);
        check("R3 irq low", {7'd0, irq}, 8'h00);
        pulse(5'b01000); check("R7 ep2 bit", rd_data, 8'h10); do_read(v);
        pulse(5'b10000); check("R7 bus reset bit", rd_data, 8'h20); do_read(v);
        check("R2 cleared again", rd_data, 8'h00);
    endtask

    task automatic t_resume();
        logic [7:0] v;
        pulse(5'b00100);
        check("R4 resume without suspend", rd_data, 8'h00);
        pulse(5'b00010);
        check("R7 suspend bit", rd_data, 8'h04);
        do_read(v);
        pulse(5'b00100);
        check("R4 resume in suspend", rd_data, 8'h08);
        do_read(v);
        pulse(5'b00100);
        check("R9 second resume ignored", rd_data, 8'h00);
    endtask

    task automatic t_ep0();
        logic [7:0] v;
        for (int i = 0; i < 5; i++) begin
            bit rise;
            rise = (i % 2) == 0;
            set_f0(i, 1'b1);
            check(rise ? "R5 active rise" : "R6 inactive rise", rd_data,
                  rise ? 8'h01 : 8'h00);
            do_read(v);
            repeat (2) @(negedge clk);
            check(rise ? "R5 held high" : "R6 held high", rd_data, 8'h00);
            set_f0(i, 1'b0);
            check(rise ? "R5 inactive fall" : "R6 active fall", rd_data,
                  rise ? 8'h00 : 8'h01);
            do_read(v);
        end
    endtask

    task automatic t_collide();
        logic [7:0] v;
        @(negedge clk); rd_en = 1'b1; stb = 5'b01000; v = rd_data;
        @(negedge clk); rd_en = 1'b0; stb = '0;
        check("R8 read value", v, 8'h00);
        check("R8 event survives read", rd_data, 8'h10);
        do_read(v);
    endtask

    task automatic t_all();
        logic [7:0] v;
        pulse(5'b00010);
        do_read(v);
        @(negedge clk); stb = 5'b11111; f0[0] = 1'b1;
        @(negedge clk); stb = '0; f0[0] = 1'b0;
        check("R1 full layout", rd_data, 8'h3F);
        do_read(v);
        check("R1 read all", v, 8'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobes();
        t_resume();
        t_ep0();
        t_collide();
        t_all();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule